// File: doc/BRIEF.md
# Rotate-Through-Carry Left Unit

This unit performs a left rotation in which the carry flag acts as one more bit above the operand's top bit. The ring being rotated is therefore one bit wider than the selected operand size: 9, 17, 33 or 65 bits. On each one-bit step the carry enters at bit 0 and the operand's top bit leaves into the carry. It is meant to sit in the shift/rotate lane of a 64-bit integer execution stage. Decode supplies an operand, a size code, a raw 8-bit count (taken from an immediate or from the low byte of a count register, both treated the same) and the current carry and overflow flags.

The unit cuts the raw count down first. For 64-bit operands it keeps the low six bits and for the other sizes the low five. For byte and halfword operands it then reduces that value modulo the ring length. One clock edge later it returns the rotated value, zero-extended above the selected size, together with the new carry, the new overflow and a flag-write enable. A count that masks to zero changes nothing and requests no flag write. Merging the result into a wider register is left to the caller.

Top module: `rcl_unit`

## Requirements
- R1: Outputs are registered. `out_valid` equals `in_valid` from one clock earlier, and every output is zero while `rst_n` is low.
- R2: `size` selects the operand width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Only the low bits of `operand` up to that width are used, and `result` bits above that width are zero.
- R3: A rotation by one moves `cf_in` into result bit 0 and the operand's top bit into `cf_out`.
- R4: For size 3 the count is taken as `count[5:0]`. For all other sizes it is `count[4:0]`, so a count of 33 on a 32-bit operand acts as a count of 1.
- R5: For size 0 the masked count is reduced modulo 9, and for size 1 modulo 17. A rotation by the full ring length returns both the operand and the carry unchanged.
- R6: When the masked count is zero, `result` equals the operand, `cf_out` = `cf_in`, `of_out` = `of_in` and `flag_we` = 0.
- R7: When the masked count is nonzero, `flag_we` = 1. If the reduced count is also nonzero, `of_out` is the result's top bit XOR `cf_out`. Otherwise `of_out` = `of_in` and `cf_out` = `cf_in`.
- R8: A rotation by n (1 ≤ n ≤ width) places the old carry at result bit n-1 and matches n repeated one-bit steps over the width+1 ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| size | input | 2 | Operand width code (0:8, 1:16, 2:32, 3:64) |
| operand | input | 64 | Value to rotate |
| count | input | 8 | Raw rotate count |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result present |
| result | output | 64 | Rotated value, zero above the width |
| cf_out | output | 1 | New carry flag |
| of_out | output | 1 | New overflow flag |
| flag_we | output | 1 | Flags are to be written |

## Verification
Random operands, carry and overflow values, sizes and full-range counts from 0 to 255 are compared against a model that loops one-bit steps over the width+1 ring. This exercises masking, modulo reduction and carry insertion together. Directed cases use known values for single steps with and without carry, for carry insertion at bit n-1, and for count 33 on a 32-bit operand, which separates five-bit from six-bit masking. Counts of 9 and 17 show whether the modulo is taken over the ring or over the data width. Counts of 0, 32 and 64 separate the masked-zero bypass, where flags are held, from real rotations.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
    localparam int unsigned RCL_DW  = 64;
    localparam int unsigned RCL_CW  = 8;
    localparam int unsigned RCL_NW  = 7;
    localparam int unsigned RCL_NSZ = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } rcl_size_e;

    typedef struct packed {
        logic              vld;
        logic [RCL_DW-1:0] res;
        logic              cf;
        logic              of;
        logic              we;
    } rcl_out_s;
endpackage

// File: rtl/rcl_count_reduce.sv
module rcl_count_reduce
    import rcl_pkg::*;
#(
    parameter int unsigned CNT_W = RCL_CW,
    parameter int unsigned N_W   = RCL_NW
) (
    input  rcl_size_e        size,
    input  logic [CNT_W-1:0] raw,
    output logic             masked_nz,
    output logic [N_W-1:0]   reduced
);
    logic [N_W-1:0] masked;

    always_comb begin
        masked = '0;
        if (size == SZ_DBL) masked[5:0] = raw[5:0];
        else                masked[4:0] = raw[4:0];
        masked_nz = (masked != '0);
        unique case (size)
            SZ_BYTE: reduced = masked % N_W'(9);
            SZ_HALF: reduced = masked % N_W'(17);
            default: reduced = masked;
        endcase
    end
endmodule

// File: rtl/rcl_lane.sv
module rcl_lane
    import rcl_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned N_W    = RCL_NW
) (
    input  logic [LANE_W-1:0] val,
    input  logic              cy_in,
    input  logic [N_W-1:0]    n,
    output logic [LANE_W-1:0] rot,
    output logic              cy_out
);
    localparam int unsigned RING_W = LANE_W + 1;

    logic [RING_W-1:0]   ring;
    logic [2*RING_W-1:0] dbl;
    logic [2*RING_W-1:0] shifted;

    always_comb begin
        ring    = {cy_in, val};
        dbl     = {ring, ring};
        shifted = dbl << n;
        rot     = shifted[RING_W +: LANE_W];
        cy_out  = shifted[2*RING_W-1];
    end
endmodule

// File: rtl/rcl_unit.sv
module rcl_unit
    import rcl_pkg::*;
#(
    parameter int unsigned DATA_W = RCL_DW,
    parameter int unsigned CNT_W  = RCL_CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  count,
    input  logic              cf_in,
    input  logic              of_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              cf_out,
    output logic              of_out,
    output logic              flag_we
);
    localparam int unsigned N_W = RCL_NW;

    rcl_size_e      size_e;
    logic           masked_nz;
    logic [N_W-1:0] red_n;

    logic [DATA_W-1:0] lane_res [RCL_NSZ];
    logic              lane_cy  [RCL_NSZ];
    logic              lane_msb [RCL_NSZ];

    rcl_out_s out_d, out_q;

    assign size_e = rcl_size_e'(size);

    rcl_count_reduce #(.CNT_W(CNT_W), .N_W(N_W)) u_cnt (
        .size      (size_e),
        .raw       (count),
        .masked_nz (masked_nz),
        .reduced   (red_n)
    );

    for (genvar g = 0; g < RCL_NSZ; g++) begin : g_lane
        localparam int unsigned LW = 8 << g;
        logic [LW-1:0] rot_w;
        logic          cy_w;

        rcl_lane #(.LANE_W(LW), .N_W(N_W)) u_lane (
            .val    (operand[LW-1:0]),
            .cy_in  (cf_in),
            .n      (red_n),
            .rot    (rot_w),
            .cy_out (cy_w)
        );

        always_comb begin
            lane_res[g]        = '0;
            lane_res[g][LW-1:0] = rot_w;
            lane_cy[g]         = cy_w;
            lane_msb[g]        = rot_w[LW-1];
        end
    end

    always_comb begin
        out_d.vld = in_valid;
        out_d.res = lane_res[size];
        out_d.cf  = lane_cy[size];
        out_d.we  = masked_nz;
        if (masked_nz && (red_n != '0)) out_d.of = lane_msb[size] ^ lane_cy[size];
        else                            out_d.of = of_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign result    = out_q.res;
    assign cf_out    = out_q.cf;
    assign of_out    = out_q.of;
    assign flag_we   = out_q.we;
endmodule

// File: rtl/rcl_unit_chk.sv
module rcl_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  size,
    input logic [63:0] operand,
    input logic [7:0]  count,
    input logic        cf_in,
    input logic        of_in,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        cf_out,
    input logic        of_out,
    input logic        flag_we
);
    function automatic logic [63:0] wmask(input logic [1:0] s);
        case (s)
            2'd0:    return 64'hFF;
            2'd1:    return 64'hFFFF;
            2'd2:    return 64'hFFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic logic top_bit(input logic [1:0] s, input logic [63:0] v);
        case (s)
            2'd0:    return v[7];
            2'd1:    return v[15];
            2'd2:    return v[31];
            default: return v[63];
        endcase
    endfunction

    a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(rst_n)) |-> out_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((result & ~wmask($past(size))) == 64'd0));
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size == 2'd3 ? count[5:0] == 6'd1 : count[4:0] == 5'd1))
        |-> (result[0] == $past(cf_in) && cf_out == $past(top_bit(size, operand))));
    a_r6_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !flag_we) |-> (cf_out == $past(cf_in) && of_out == $past(of_in)
                                     && result == ($past(operand) & wmask($past(size)))));
    a_r7_of_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result != ($past(operand) & wmask($past(size))))
        |-> (flag_we && of_out == (top_bit($past(size), result) ^ cf_out)));
endmodule

bind rcl_unit rcl_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size(size),
    .operand(operand), .count(count), .cf_in(cf_in), .of_in(of_in),
    .out_valid(out_valid), .result(result), .cf_out(cf_out),
    .of_out(of_out), .flag_we(flag_we)
);

// File: tb/rcl_unit_test.sv
module rcl_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  size = '0;
    logic [63:0] operand = '0;
    logic [7:0]  count = '0;
    logic        cf_in = 1'b0;
    logic        of_in = 1'b0;
    logic        out_valid, cf_out, of_out, flag_we;
    logic [63:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rcl_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size(size),
        .operand(operand), .count(count), .cf_in(cf_in), .of_in(of_in),
        .out_valid(out_valid), .result(result), .cf_out(cf_out),
        .of_out(of_out), .flag_we(flag_we)
    );

    function automatic int width_of(input logic [1:0] s);
        return 8 << s;
    endfunction

    // Reference: repeated one-bit steps over the width+1 ring
    function automatic void model(input logic [1:0] s, input logic [63:0] op,
                                  input logic [7:0] c, input logic ci, input logic oi,
                                  output logic [63:0] r, output logic co,
                                  output logic oo, output logic we);
        int w = width_of(s);
        int m = (s == 2'd3) ? int'(c & 8'h3F) : int'(c & 8'h1F);
        logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        logic [63:0] v = op & msk;
        logic cy = ci;
        for (int i = 0; i < m; i++) begin
            logic nc = v[w-1];
            v  = ((v << 1) | {63'd0, cy}) & msk;
            cy = nc;
        end
        r  = v;
        co = cy;
        we = (m != 0);
        oo = (m != 0 && (m % (w + 1)) != 0) ? (v[w-1] ^ cy) : oi;
    endfunction

    task automatic check(input string tag, input logic [63:0] er, input logic ec,
                         input logic eo, input logic ew);
        n_chk++;
        if (out_valid !== 1'b1 || result !== er || cf_out !== ec
            || of_out !== eo || flag_we !== ew) begin
            n_bad++;
            $display("FAIL %s: got v=%0b r=%h cf=%0b of=%0b we=%0b exp v=1 r=%h cf=%0b of=%0b we=%0b",
                     tag, out_valid, result, cf_out, of_out, flag_we, er, ec, eo, ew);
        end
    endtask

    task automatic run_op(input string tag, input logic [1:0] s, input logic [63:0] op,
                          input logic [7:0] c, input logic ci, input logic oi);
        logic [63:0] er; logic ec, eo, ew;
        @(negedge clk);
        in_valid = 1'b1; size = s; operand = op; count = c; cf_in = ci; of_in = oi;
        model(s, op, c, ci, oi, er, ec, eo, ew);
        @(negedge clk);
        check(tag, er, ec, eo, ew);
        in_valid = 1'b0;
    endtask

    task automatic directed(input string tag, input logic [1:0] s, input logic [63:0] op,
                            input logic [7:0] c, input logic ci, input logic [63:0] er,
                            input logic ec);
        @(negedge clk);
        in_valid = 1'b1; size = s; operand = op; count = c; cf_in = ci; of_in = 1'b0;
        @(negedge clk);
        n_chk++;
        if (result !== er || cf_out !== ec) begin
            n_bad++;
            $display("FAIL %s: got r=%h cf=%0b exp r=%h cf=%0b", tag, result, cf_out, er, ec);
        end
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int seed = 32'h5EED_0417;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        in_valid = 1'b1; operand = '1; count = 8'd1; cf_in = 1'b1;
        @(negedge clk);
        n_chk++;  // R1 reset state
        if (out_valid !== 1'b0 || result !== 64'd0 || cf_out !== 1'b0 || flag_we !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got v=%0b r=%h exp v=0 r=0", out_valid, result);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;  // R1 idle after reset
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 idle: got v=%0b exp v=0", out_valid);
        end

        directed("R3 msb+cf",      2'd0, 64'h81, 8'd1, 1'b1, 64'h03, 1'b1);
        directed("R3 cf into b0",  2'd0, 64'h42, 8'd1, 1'b1, 64'h85, 1'b0);
        directed("R3 half top",    2'd1, 64'h8000, 8'd1, 1'b1, 64'h0001, 1'b1);
        directed("R8 byte by4",    2'd0, 64'h01, 8'd4, 1'b1, 64'h18, 1'b0);
        directed("R8 half by8",    2'd1, 64'h1234, 8'd8, 1'b0, 64'h3409, 1'b0);
        directed("R8 dbl by16",    2'd3, 64'h1234_5678_9ABC_DEF0, 8'd16, 1'b0,
                 64'h5678_9ABC_DEF0_091A, 1'b0);
        directed("R4 word by33",   2'd2, 64'h1234_5678, 8'd33, 1'b0, 64'h2468_ACF0, 1'b0);
        directed("R5 byte by9",    2'd0, 64'h42, 8'd9, 1'b0, 64'h42, 1'b0);
        directed("R5 half by17",   2'd1, 64'h1234, 8'd17, 1'b1, 64'h1234, 1'b1);
        directed("R2 upper bits",  2'd0, 64'hFFFF_FFFF_FFFF_FF42, 8'd1, 1'b0, 64'h84, 1'b0);
        directed("R4 dbl by 0x41", 2'd3, 64'h8000_0000_0000_0000, 8'h41, 1'b0, 64'd0, 1'b1);

        run_op("R6 count0",        2'd0, 64'h42, 8'd0, 1'b1, 1'b1);
        run_op("R6 byte by32",     2'd0, 64'h5A, 8'd32, 1'b1, 1'b1);
        run_op("R6 dbl by64",      2'd3, 64'hDEAD_BEEF_0000_1111, 8'd64, 1'b0, 1'b1);
        run_op("R7 byte by9 of",   2'd0, 64'hC3, 8'd9, 1'b1, 1'b1);
        run_op("R7 of by1",        2'd2, 64'h4000_0000, 8'd1, 1'b0, 1'b0);
        run_op("R4 word by 0xE1",  2'd2, 64'hF0F0_1234, 8'hE1, 1'b1, 1'b0);

        for (int i = 0; i < 4000; i++) begin
            logic [1:0] s = 2'($urandom_range(0, 3));
            logic [63:0] op = {$urandom, $urandom};
            logic [7:0] c = (i % 3 == 0) ? 8'($urandom_range(0, 2)) : 8'($urandom_range(0, 255));
            run_op("R8 random", s, op, c, 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule